// File: doc/BRIEF.md
# Multichannel SAR ADC Serial Controller

This block drives a multichannel 14-bit successive-approximation converter over a four-wire serial link, with the converter run from the serial clock supplied by the host. A one-cycle start request latches the channel number and the two input-mode flags. The block then lowers chip select and shifts out an 8-bit command on the falling edges of its own serial clock. It waits for the converter's ready strobe to fall, clocks in a 16-bit frame and keeps its upper 14 bits as the result. Finally it raises chip select and reports the result with a one-cycle valid pulse.

The serial clock is derived from the system clock. Each half period lasts `half_div_i + 1` clock cycles, and the clock rests low whenever chip select is high. The strobe passes through a two-stage synchronizer. For the first result bit to be caught, the strobe must fall at least three system clocks before the next rising serial edge. A converter that answers on a falling serial edge satisfies this when `half_div_i` is 3 or more. If the strobe never falls, a watchdog counted in serial periods ends the transaction and flags a timeout.

Top module: `adc_serial_ctrl`

## Requirements
- R1: Out of reset, cs_no is 1, sclk_o and din_o are 0, and busy_o, valid_o and timeout_o are 0.
- R2: A start_i pulse while idle drives cs_no low at the next clock edge. cs_no then stays low without a break until the cycle in which valid_o or timeout_o is high, so each transaction makes exactly one low period.
- R3: On the first 8 rising edges of sclk_o after cs_no falls, din_o carries the command MSB first: bit 7 = 1, bits 6..4 = chan_i, bit 3 = sgl_i, bit 2 = uni_i, bits 1..0 = 11. din_o only changes away from rising edges.
- R4: sclk_o is low while cs_no is high. The first rising edge comes half_div_i + 2 clocks after cs_no falls, and each high phase lasts half_div_i + 1 clocks.
- R5: After a falling edge on sstrb_i during the wait phase, dout_i is captured on the next 16 rising sclk_o edges. result_o equals the first 14 captured bits, MSB first, and the last 2 bits are dropped.
- R6: At the end of a read, valid_o is high for exactly one cycle, the same cycle in which cs_no returns high. result_o keeps its value until the next completed read.
- R7: If tmo_lim_i falling sclk_o edges pass in the wait phase with no strobe fall, cs_no returns high, timeout_o pulses for one cycle, valid_o stays low and result_o is unchanged.
- R8: start_i is ignored while busy_o is high, including the final cycle of a transaction.
- R9: dout_i has no effect on result_o outside the 16 read edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle conversion request |
| chan_i | input | 3 | Channel select |
| sgl_i | input | 1 | 1 = single-ended, 0 = differential |
| uni_i | input | 1 | 1 = unipolar, 0 = bipolar |
| half_div_i | input | DIV_W | Serial half period minus one, in clocks |
| tmo_lim_i | input | TMO_W | Strobe wait limit in serial periods |
| busy_o | output | 1 | Transaction in progress |
| result_o | output | RES_W | Last conversion result |
| valid_o | output | 1 | One-cycle pulse when result_o is new |
| timeout_o | output | 1 | One-cycle pulse when the strobe wait expired |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to converter |
| din_o | output | 1 | Command data to converter |
| dout_i | input | 1 | Result data from converter |
| sstrb_i | input | 1 | Converter ready strobe; falling edge = data ready |

## Verification
The sharpest collision is between completion and a new request: a start_i pulse that lands in the very cycle where valid_o pulses and cs_no rises. The bench watches for valid_o at the falling clock edge and raises start_i right there, so the start is sampled in the closing state. It then checks that busy_o drops, that cs_no makes no new falling edge in the following cycles, and that the captured result is intact. A second case drives start_i with a different channel in the middle of a transaction and confirms that the command bits seen on the link do not change.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CS_LO,
    ST_CMD,
    ST_WAIT,
    ST_READ,
    ST_CS_HI
  } ctrl_state_e;

  // start=1, channel, input mode, polarity, external-clock code 11
  function automatic logic [CMD_W-1:0] build_cmd(input logic [2:0] chan,
                                                 input logic sgl,
                                                 input logic uni);
    return {1'b1, chan, sgl, uni, 2'b11};
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             wrap;

  assign wrap   = en_i && (cnt_q >= half_div_i);
  assign rise_o = wrap && !sclk_q;
  assign fall_o = wrap && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r4_rise_announced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> $past(rise_o));

  a_r4_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sclk_q);

endmodule

// File: rtl/adc_fall_det.sv
module adc_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], sig_i};
  end

  assign fall_o = sh_q[STAGES] && !sh_q[STAGES-1];

  a_r5_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
  parameter int FRAME_W = 16,
  parameter int RES_W   = 14,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [RES_W-1:0] head_o,
  output logic             full_o
);

  logic [FRAME_W-1:0] data_q;
  logic [CNT_W-1:0]   cnt_q;

  assign full_o = (cnt_q == CNT_W'(FRAME_W));
  assign head_o = data_q[FRAME_W-1 -: RES_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (shift_i && !full_o) begin
      data_q <= {data_q[FRAME_W-2:0], bit_i};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  a_r5_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_W));

endmodule

// File: rtl/adc_serial_ctrl.sv
module adc_serial_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int RES_W       = 14,
  parameter int FRAME_W     = 16,
  parameter int DIV_W       = 8,
  parameter int TMO_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       chan_i,
  input  logic             sgl_i,
  input  logic             uni_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic [TMO_W-1:0] tmo_lim_i,
  output logic             busy_o,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o,
  output logic             timeout_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             din_o,
  input  logic             dout_i,
  input  logic             sstrb_i
);

  localparam int BIT_CW = $clog2(CMD_W + 1);

  ctrl_state_e state_q, state_d;

  logic [CMD_W-1:0]  tx_q;
  logic [BIT_CW-1:0] bit_cnt_q;
  logic [TMO_W:0]    tmo_cnt_q;
  logic [TMO_W:0]    tmo_nxt;
  logic              tmo_flag_q;
  logic [RES_W-1:0]  result_q;

  logic sclk_en, rise, fall, strb_fall;
  logic rx_clr, rx_shift, rx_full;
  logic [RES_W-1:0] rx_head;
  logic cmd_done, tmo_hit, read_done;

  assign sclk_en = (state_q == ST_CMD) || (state_q == ST_WAIT) || (state_q == ST_READ);

  adc_sclk_gen #(.DIV_W(DIV_W)) i_sclk_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (sclk_en),
    .half_div_i (half_div_i),
    .sclk_o     (sclk_o),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  adc_fall_det #(.STAGES(SYNC_STAGES)) i_strb_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sstrb_i),
    .fall_o (strb_fall)
  );

  assign rx_clr   = (state_q == ST_WAIT);
  assign rx_shift = (state_q == ST_READ) && rise;

  adc_rx_shift #(.FRAME_W(FRAME_W), .RES_W(RES_W)) i_rx_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_clr),
    .shift_i (rx_shift),
    .bit_i   (dout_i),
    .head_o  (rx_head),
    .full_o  (rx_full)
  );

  assign tmo_nxt   = tmo_cnt_q + {{TMO_W{1'b0}}, 1'b1};
  assign cmd_done  = fall && (bit_cnt_q == BIT_CW'(CMD_W));
  assign tmo_hit   = fall && (tmo_nxt >= {1'b0, tmo_lim_i});
  assign read_done = fall && rx_full;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CS_LO;
      ST_CS_LO: state_d = ST_CMD;
      ST_CMD:   if (cmd_done) state_d = ST_WAIT;
      ST_WAIT: begin
        // strobe wins over an expiring wait limit
        if (strb_fall)    state_d = ST_READ;
        else if (tmo_hit) state_d = ST_CS_HI;
      end
      ST_READ:  if (read_done) state_d = ST_CS_HI;
      ST_CS_HI: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tx_q       <= '0;
      bit_cnt_q  <= '0;
      tmo_cnt_q  <= '0;
      tmo_flag_q <= 1'b0;
      result_q   <= '0;
    end else begin
      state_q <= state_d;
      case (state_q)
        ST_IDLE: if (start_i) begin
          tx_q       <= build_cmd(chan_i, sgl_i, uni_i);
          bit_cnt_q  <= '0;
          tmo_flag_q <= 1'b0;
        end
        ST_CMD: begin
          if (rise) bit_cnt_q <= bit_cnt_q + 1'b1;
          if (fall) tx_q <= {tx_q[CMD_W-2:0], 1'b0};
        end
        ST_WAIT: if (!strb_fall && tmo_hit) tmo_flag_q <= 1'b1;
        ST_READ: if (read_done) result_q <= rx_head;
        default: ;
      endcase
      if (state_q != ST_WAIT)       tmo_cnt_q <= '0;
      else if (fall && !strb_fall)  tmo_cnt_q <= tmo_nxt;
    end
  end

  assign cs_no     = (state_q == ST_IDLE) || (state_q == ST_CS_HI);
  assign busy_o    = (state_q != ST_IDLE);
  assign din_o     = ((state_q == ST_CS_LO) || (state_q == ST_CMD)) ? tx_q[CMD_W-1] : 1'b0;
  assign valid_o   = (state_q == ST_CS_HI) && !tmo_flag_q;
  assign timeout_o = (state_q == ST_CS_HI) && tmo_flag_q;
  assign result_o  = result_q;

  a_r4_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  a_r3_din_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD && rise) |=> $stable(din_o));

  a_r6_valid_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r2_cs_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (valid_o || timeout_o));

  a_r8_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> !$fell(cs_no));

  a_r7_no_result_on_tmo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> $stable(result_o));

endmodule

// File: tb/test_adc_serial_ctrl.sv
`timescale 1ns/1ps
module test_adc_serial_ctrl;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  chan_i = '0;
  logic        sgl_i = 1'b0;
  logic        uni_i = 1'b0;
  logic [7:0]  half_div_i = 8'd3;
  logic [11:0] tmo_lim_i = 12'd16;
  logic        busy_o, valid_o, timeout_o, cs_no, sclk_o, din_o;
  logic [13:0] result_o;
  logic        dout_i, sstrb_i;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  adc_serial_ctrl i_adc_serial_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .chan_i(chan_i),
    .sgl_i(sgl_i), .uni_i(uni_i), .half_div_i(half_div_i), .tmo_lim_i(tmo_lim_i),
    .busy_o(busy_o), .result_o(result_o), .valid_o(valid_o), .timeout_o(timeout_o),
    .cs_no(cs_no), .sclk_o(sclk_o), .din_o(din_o), .dout_i(dout_i), .sstrb_i(sstrb_i)
  );

  typedef struct packed {
    logic [2:0]  chan;
    logic        sgl;
    logic        uni;
    logic [15:0] frame;
    logic [7:0]  hdiv;
    logic [3:0]  delay;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{3'd5, 1'b1, 1'b0, 16'hA5C3, 8'd3, 4'd2},
    '{3'd0, 1'b0, 1'b1, 16'hFFFF, 8'd5, 4'd1},
    '{3'd7, 1'b1, 1'b1, 16'h0002, 8'd3, 4'd4},
    '{3'd2, 1'b0, 1'b0, 16'h8001, 8'd4, 4'd3}
  };

  // converter model
  logic        model_respond = 1'b1;
  int          model_delay = 2;
  logic [15:0] model_frame = '0;
  logic [7:0]  cmd_cap = '0;
  int          cs_falls = 0;
  time         t_csf, t_rise, t_fall;

  initial forever begin
    @(negedge cs_no);
    cs_falls++;
  end

  initial forever begin
    @(negedge cs_no);
    t_csf = $time;
    @(posedge sclk_o);
    t_rise = $time;
    @(negedge sclk_o);
    t_fall = $time;
  end

  initial begin
    sstrb_i = 1'b0;
    dout_i  = 1'b1;
    forever begin
      @(negedge cs_no);
      for (int i = 0; i < 8; i++) begin
        @(posedge sclk_o);
        #1;
        cmd_cap = {cmd_cap[6:0], din_o};
      end
      @(negedge clk_i);
      sstrb_i = 1'b1;
      if (model_respond) begin
        for (int i = 0; i < model_delay; i++) @(negedge sclk_o);
        @(negedge clk_i);
        sstrb_i = 1'b0;
        dout_i  = model_frame[15];
        for (int i = 14; i >= 0; i--) begin
          @(negedge sclk_o);
          @(negedge clk_i);
          dout_i = model_frame[i];
        end
        @(posedge cs_no);
        @(negedge clk_i);
        dout_i = 1'b1;
      end else begin
        @(posedge cs_no);
        @(negedge clk_i);
        sstrb_i = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_txn(input logic [2:0] ch, input logic s, input logic u,
                        input logic [7:0] hd, input logic [11:0] lim,
                        input logic poke_at_valid,
                        output logic got_valid, output logic got_tmo,
                        output logic [13:0] res);
    @(negedge clk_i);
    chan_i = ch; sgl_i = s; uni_i = u; half_div_i = hd; tmo_lim_i = lim;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    got_valid = 1'b0;
    got_tmo   = 1'b0;
    res       = '0;
    while (busy_o) begin
      if (valid_o) begin
        got_valid = 1'b1;
        res = result_o;
        if (poke_at_valid) start_i = 1'b1;
      end
      if (timeout_o) got_tmo = 1'b1;
      @(negedge clk_i);
    end
    start_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic        gv, gt;
    logic [13:0] res;
    logic [13:0] last_res;
    int          falls0;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 cs_no", 32'(cs_no), 32'd1);
    chk("R1 sclk_o", 32'(sclk_o), 32'd0);
    chk("R1 din_o", 32'(din_o), 32'd0);
    chk("R1 busy/valid/timeout", {29'd0, busy_o, valid_o, timeout_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R1 idle after release", {30'd0, cs_no, sclk_o}, 32'd2);

    for (int v = 0; v < 4; v++) begin
      model_respond = 1'b1;
      model_delay   = int'(VECS[v].delay);
      model_frame   = VECS[v].frame;
      falls0 = cs_falls;
      do_txn(VECS[v].chan, VECS[v].sgl, VECS[v].uni, VECS[v].hdiv, 12'd16, 1'b0, gv, gt, res);
      chk("R2 one cs low period", 32'(cs_falls - falls0), 32'd1);
      chk("R3 command byte", 32'(cmd_cap),
          32'({1'b1, VECS[v].chan, VECS[v].sgl, VECS[v].uni, 2'b11}));
      chk("R4 first rise delay", 32'(t_rise - t_csf), 32'((int'(VECS[v].hdiv) + 2) * 10));
      chk("R4 high phase", 32'(t_fall - t_rise), 32'((int'(VECS[v].hdiv) + 1) * 10));
      chk("R6 valid seen, no timeout", {30'd0, gv, gt}, 32'd2);
      chk("R5 R9 result", 32'(res), 32'(VECS[v].frame[15:2]));
      repeat (5) @(negedge clk_i);
      chk("R6 result held", 32'(result_o), 32'(VECS[v].frame[15:2]));
      chk("R4 sclk idle low", {30'd0, cs_no, sclk_o}, 32'd2);
    end
    last_res = result_o;

    // R7 timeout with no strobe fall
    model_respond = 1'b0;
    falls0 = cs_falls;
    do_txn(3'd4, 1'b1, 1'b0, 8'd3, 12'd4, 1'b0, gv, gt, res);
    chk("R7 timeout pulse, no valid", {30'd0, gv, gt}, 32'd1);
    chk("R7 result unchanged", 32'(result_o), 32'(last_res));
    chk("R7 cs high after", 32'(cs_no), 32'd1);
    chk("R7 one cs low period", 32'(cs_falls - falls0), 32'd1);
    repeat (4) @(negedge clk_i);

    // R8 start during command phase ignored
    model_respond = 1'b1;
    model_delay   = 2;
    model_frame   = 16'h3C5A;
    falls0 = cs_falls;
    fork
      do_txn(3'd6, 1'b0, 1'b1, 8'd3, 12'd16, 1'b0, gv, gt, res);
      begin
        repeat (12) @(negedge clk_i);
        chan_i = 3'd1; sgl_i = 1'b1; uni_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
      end
    join
    chk("R8 command unchanged", 32'(cmd_cap), 32'({1'b1, 3'd6, 1'b0, 1'b1, 2'b11}));
    chk("R8 one cs low period", 32'(cs_falls - falls0), 32'd1);
    chk("R8 R5 result", 32'(res), 32'(16'h3C5A >> 2));

    // R8 start in the completion cycle ignored
    model_frame = 16'h9003;
    falls0 = cs_falls;
    do_txn(3'd3, 1'b1, 1'b1, 8'd4, 12'd16, 1'b1, gv, gt, res);
    chk("R6 valid at completion", 32'(gv), 32'd1);
    repeat (4) @(negedge clk_i);
    chk("R8 no restart after completion", 32'(cs_falls - falls0), 32'd1);
    chk("R8 idle after completion", {30'd0, busy_o, cs_no}, 32'd1);
    chk("R5 result after collision", 32'(result_o), 32'(16'h9003 >> 2));

    finish_run();
  end

endmodule